// File: doc/BRIEF.md
# SMBus Slave Command Dispatcher

This block sits behind a bit-level SMBus/I2C slave engine that has already matched the device address. It receives byte-level events: a start or repeated start together with the transfer direction, a stop, each byte the master writes, and each request for a byte the master wants to read. For every start and every written byte it returns one ACK/NACK decision. It supplies read data, and it drives write strobes into two storage spaces that live outside it. The first is a 128-byte volatile register file. The second is a 512-byte nonvolatile array.

The value of the command byte alone sets the meaning of a write transaction. Commands 00h to 7Fh address the register file directly. A command with its upper seven bits equal to 1000000b carries bit 8 of a nonvolatile address. A0h opens a block write. Any other command value is rejected. The block keeps one pointer for each space and remembers which space was pointed at last. A pointer set in one transaction stays valid across a repeated start or a stop, so the following read or block write works at that pointer.

A nonvolatile byte takes a long time to program. After each nonvolatile write strobe the block reports itself busy for a fixed number of clock cycles and refuses every access during that time.

Top module: `smbd_cmd_dispatch`

## Requirements
- R1: A write transaction whose command byte is 00h–7Fh sets the register-file pointer to that command value and selects the register file as the current space, even when the master stops right after the command (send byte).
- R2: In a register-file write, the first data byte after a 00h–7Fh command is ACKed and written at the command address. Any further data byte in the same transaction is NACKed and writes nothing.
- R3: After command 80h or 81h, the first data byte is ACKed and loads the nonvolatile pointer with {command bit 0, data byte}. It selects the nonvolatile space and produces no write strobe.
- R4: A second data byte after 80h/81h is written to the nonvolatile array at that pointer only while `nv_wen_i` is 1. When `nv_wen_i` is 0 the byte is NACKed and no strobe is issued. Any later byte in that transaction is NACKed.
- R5: Command A0h is ACKed and the next byte is taken as a byte count N. The next N data bytes are each ACKed and written into the current space at its pointer, and the pointer is incremented after each one. Data bytes beyond N are NACKed and write nothing.
- R6: In a read transaction, each read request returns the byte at the current space's pointer and then increments that pointer. The register-file pointer wraps from 7Fh to 00h and the nonvolatile pointer wraps from 1FFh to 000h. A read request outside an accepted read transaction returns FFh and moves no pointer.
- R7: Both pointers and the current-space selection survive a stop and a repeated start. A start or a stop returns the byte position to the command byte.
- R8: Each nonvolatile write strobe makes `busy_o` high for exactly PROG_CYCLES cycles, starting in the strobe's own cycle. While `busy_o` is high, every start is NACKed, its transaction is refused, and any nonvolatile data byte is NACKed without a strobe.
- R9: A command other than 00h–7Fh, 80h, 81h and A0h is NACKed, as is every later byte of that transaction. Neither memory nor any pointer changes.
- R10: `ack_vld_o` pulses exactly one cycle after each `start_i` or `byte_vld_i`. `rd_vld_o` pulses exactly one cycle after each `rd_req_i`. A write strobe appears in the same cycle as the ACK of the byte that caused it.
- R11: After reset both pointers are zero, the register file is the current space, `busy_o` is low and no acknowledge, read-valid or strobe output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated start with address matched (one-cycle pulse) |
| rw_i | input | 1 | Direction bit sampled with `start_i`; 1 = read |
| stop_i | input | 1 | Stop condition (one-cycle pulse) |
| byte_vld_i | input | 1 | A byte written by the master is available |
| byte_i | input | 8 | Byte written by the master |
| rd_req_i | input | 1 | Front end needs the next read byte |
| nv_wen_i | input | 1 | Nonvolatile write-enable bit held in the array's configuration |
| ram_rdata_i | input | 8 | Register-file data at `ram_addr_o` |
| ee_rdata_i | input | 8 | Nonvolatile data at `ee_addr_o` |
| ack_vld_o | output | 1 | An ACK/NACK decision is presented |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_vld_o | output | 1 | Read byte presented |
| rd_data_o | output | 8 | Read byte |
| ram_we_o | output | 1 | Register-file write strobe |
| ram_addr_o | output | 7 | Write address while strobing, else the register-file pointer |
| ram_wdata_o | output | 8 | Register-file write data |
| ee_we_o | output | 1 | Nonvolatile write strobe |
| ee_addr_o | output | 9 | Write address while strobing, else the nonvolatile pointer |
| ee_wdata_o | output | 8 | Nonvolatile write data |
| busy_o | output | 1 | Nonvolatile programming in progress |

## Verification
The bench sweeps every register-file address with a single-byte write. It reads each one back after a pointer-setting send byte, sometimes across a stop and sometimes across a repeated start. A design that forgot the pointer at the stop, or wrote at the pointer instead of at the command address, would read back the wrong values. Every command value with bit 7 set is swept. Commands such as 82h or A1h must be refused and must leave memory untouched, which catches a decoder that compares too few bits. The wrap of both pointers, a byte count that runs out, and a write attempt while the write-enable bit is low are all covered. The busy window is measured cycle by cycle, and accesses are attempted inside it. A timer that is off by one, or a block write that commits two nonvolatile bytes back to back, shows up there as a wrong count or an unexpected ACK.

// File: rtl/smbd_pkg.sv
package smbd_pkg;

    localparam int RAM_AW  = 7;
    localparam int EE_AW   = 9;
    localparam int EE_HI_W = EE_AW - 8;

    localparam logic [7:0] CMD_EE_BASE = 8'h80;
    localparam logic [7:0] CMD_BLOCK   = 8'hA0;
    localparam logic [7:0] RD_FILL     = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_RAM_DATA, ST_EE_LO, ST_EE_DATA,
        ST_BLK_CNT, ST_BLK_DATA, ST_READ, ST_REFUSE
    } txn_st_e;

    typedef enum logic {SP_RAM, SP_EE} space_e;

    typedef enum logic [1:0] {CK_RAM, CK_EE, CK_BLOCK, CK_BAD} cmd_kind_e;

    typedef struct packed {
        logic ack_vld;
        logic ack;
        logic rd_vld;
        logic rd_take;
        logic ram_wr;
        logic ram_at_ptr;
        logic ee_wr;
        logic ld_ram;
        logic ld_ee;
        logic inc;
    } act_t;

    function automatic cmd_kind_e classify(input logic [7:0] c);
        if (!c[7])                                      return CK_RAM;
        if (c[7:EE_HI_W] == CMD_EE_BASE[7:EE_HI_W])     return CK_EE;
        if (c == CMD_BLOCK)                             return CK_BLOCK;
        return CK_BAD;
    endfunction

endpackage

// File: rtl/smbd_prog_timer.sv
module smbd_prog_timer #(
    parameter int PROG_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PROG_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load_i)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/smbd_ptr_bank.sv
module smbd_ptr_bank
    import smbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_ram_i,
    input  logic [RAM_AW-1:0] ram_val_i,
    input  logic              ld_ee_i,
    input  logic [EE_AW-1:0]  ee_val_i,
    input  logic              inc_i,
    output space_e            space_o,
    output logic [RAM_AW-1:0] ram_ptr_o,
    output logic [EE_AW-1:0]  ee_ptr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            space_o   <= SP_RAM;
            ram_ptr_o <= '0;
            ee_ptr_o  <= '0;
        end else if (ld_ram_i) begin
            space_o   <= SP_RAM;
            ram_ptr_o <= ram_val_i;
        end else if (ld_ee_i) begin
            space_o   <= SP_EE;
            ee_ptr_o  <= ee_val_i;
        end else if (inc_i) begin
            if (space_o == SP_RAM) ram_ptr_o <= ram_ptr_o + 1'b1;
            else                   ee_ptr_o  <= ee_ptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/smbd_fsm.sv
module smbd_fsm
    import smbd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               rw_i,
    input  logic               stop_i,
    input  logic               byte_vld_i,
    input  logic [7:0]         byte_i,
    input  logic               rd_req_i,
    input  logic               busy_i,
    input  logic               wen_i,
    input  space_e             space_i,
    output act_t               act_o,
    output logic [RAM_AW-1:0]  cmd_addr_o,
    output logic [EE_HI_W-1:0] ee_hi_o
);
    txn_st_e   st_q, st_d;
    logic [7:0] left_q, left_d;
    cmd_kind_e kind;
    logic       ee_ok;

    assign kind  = classify(byte_i);
    assign ee_ok = wen_i && !busy_i;

    always_comb begin
        act_o  = '0;
        st_d   = st_q;
        left_d = left_q;
        if (start_i) begin
            act_o.ack_vld = 1'b1;
            act_o.ack     = !busy_i;
            st_d = busy_i ? ST_REFUSE : (rw_i ? ST_READ : ST_CMD);
        end else if (stop_i) begin
            st_d = ST_IDLE;
        end else if (byte_vld_i) begin
            act_o.ack_vld = 1'b1;
            unique case (st_q)
                ST_CMD: begin
                    act_o.ack = (kind != CK_BAD);
                    unique case (kind)
                        CK_RAM:   begin act_o.ld_ram = 1'b1; st_d = ST_RAM_DATA; end
                        CK_EE:    st_d = ST_EE_LO;
                        CK_BLOCK: st_d = ST_BLK_CNT;
                        default:  st_d = ST_REFUSE;
                    endcase
                end
                ST_RAM_DATA: begin
                    act_o.ack    = 1'b1;
                    act_o.ram_wr = 1'b1;
                    st_d = ST_REFUSE;
                end
                ST_EE_LO: begin
                    act_o.ack   = 1'b1;
                    act_o.ld_ee = 1'b1;
                    st_d = ST_EE_DATA;
                end
                ST_EE_DATA: begin
                    act_o.ack   = ee_ok;
                    act_o.ee_wr = ee_ok;
                    st_d = ST_REFUSE;
                end
                ST_BLK_CNT: begin
                    act_o.ack = 1'b1;
                    left_d = byte_i;
                    st_d = ST_BLK_DATA;
                end
                ST_BLK_DATA: begin
                    if (left_q != '0 && (space_i == SP_RAM || ee_ok)) begin
                        act_o.ack = 1'b1;
                        act_o.inc = 1'b1;
                        left_d = left_q - 1'b1;
                        if (space_i == SP_RAM) begin
                            act_o.ram_wr     = 1'b1;
                            act_o.ram_at_ptr = 1'b1;
                        end else begin
                            act_o.ee_wr = 1'b1;
                        end
                    end
                end
                default: act_o.ack = 1'b0;
            endcase
        end else if (rd_req_i) begin
            act_o.rd_vld  = 1'b1;
            act_o.rd_take = (st_q == ST_READ);
            act_o.inc     = (st_q == ST_READ);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            left_q     <= '0;
            cmd_addr_o <= '0;
            ee_hi_o    <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            if (byte_vld_i && !start_i && !stop_i && st_q == ST_CMD) begin
                cmd_addr_o <= byte_i[RAM_AW-1:0];
                ee_hi_o    <= byte_i[EE_HI_W-1:0];
            end
        end
    end
endmodule

// File: rtl/smbd_cmd_dispatch.sv
module smbd_cmd_dispatch
    import smbd_pkg::*;
#(
    parameter int PROG_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rw_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              rd_req_i,
    input  logic              nv_wen_i,
    input  logic [7:0]        ram_rdata_i,
    input  logic [7:0]        ee_rdata_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              rd_vld_o,
    output logic [7:0]        rd_data_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [7:0]        ram_wdata_o,
    output logic              ee_we_o,
    output logic [EE_AW-1:0]  ee_addr_o,
    output logic [7:0]        ee_wdata_o,
    output logic              busy_o
);
    act_t               act;
    space_e             space;
    logic [RAM_AW-1:0]  ram_ptr, cmd_addr, ram_waddr_q;
    logic [EE_AW-1:0]   ee_ptr, ee_waddr_q;
    logic [EE_HI_W-1:0] ee_hi;

    smbd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rw_i       (rw_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .rd_req_i   (rd_req_i),
        .busy_i     (busy_o),
        .wen_i      (nv_wen_i),
        .space_i    (space),
        .act_o      (act),
        .cmd_addr_o (cmd_addr),
        .ee_hi_o    (ee_hi)
    );

    smbd_ptr_bank u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ld_ram_i  (act.ld_ram),
        .ram_val_i (byte_i[RAM_AW-1:0]),
        .ld_ee_i   (act.ld_ee),
        .ee_val_i  ({ee_hi, byte_i}),
        .inc_i     (act.inc),
        .space_o   (space),
        .ram_ptr_o (ram_ptr),
        .ee_ptr_o  (ee_ptr)
    );

    smbd_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (act.ee_wr),
        .busy_o (busy_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vld_o   <= 1'b0;
            ack_o       <= 1'b0;
            rd_vld_o    <= 1'b0;
            rd_data_o   <= RD_FILL;
            ram_we_o    <= 1'b0;
            ram_waddr_q <= '0;
            ram_wdata_o <= '0;
            ee_we_o     <= 1'b0;
            ee_waddr_q  <= '0;
            ee_wdata_o  <= '0;
        end else begin
            ack_vld_o <= act.ack_vld;
            ack_o     <= act.ack;
            rd_vld_o  <= act.rd_vld;
            if (act.rd_vld)
                rd_data_o <= !act.rd_take ? RD_FILL :
                             (space == SP_RAM) ? ram_rdata_i : ee_rdata_i;
            ram_we_o <= act.ram_wr;
            ee_we_o  <= act.ee_wr;
            if (act.ram_wr) begin
                ram_waddr_q <= act.ram_at_ptr ? ram_ptr : cmd_addr;
                ram_wdata_o <= byte_i;
            end
            if (act.ee_wr) begin
                ee_waddr_q <= ee_ptr;
                ee_wdata_o <= byte_i;
            end
        end
    end

    assign ram_addr_o = ram_we_o ? ram_waddr_q : ram_ptr;
    assign ee_addr_o  = ee_we_o  ? ee_waddr_q  : ee_ptr;
endmodule

// File: rtl/smbd_chk.sv
module smbd_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic byte_vld_i,
    input logic rd_req_i,
    input logic nv_wen_i,
    input logic ack_vld_o,
    input logic ack_o,
    input logic rd_vld_o,
    input logic ram_we_o,
    input logic ee_we_o,
    input logic busy_o
);
    assert_ack_follows_event_R10: assert property (@(posedge clk) disable iff (rst)
        ack_vld_o |-> $past(start_i || byte_vld_i));

    assert_rd_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        rd_vld_o |-> $past(rd_req_i));

    assert_strobe_acked_R10: assert property (@(posedge clk) disable iff (rst)
        (ram_we_o || ee_we_o) |-> (ack_vld_o && ack_o));

    assert_ee_needs_wen_R4: assert property (@(posedge clk) disable iff (rst)
        ee_we_o |-> $past(nv_wen_i));

    assert_ee_not_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        ee_we_o |-> !$past(busy_o));

    assert_busy_with_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        ee_we_o |-> busy_o);

    assert_busy_refuses_start_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> (ack_vld_o && !ack_o));

    assert_single_space_R5: assert property (@(posedge clk) disable iff (rst)
        !(ram_we_o && ee_we_o));

    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(busy_o || ack_vld_o || rd_vld_o || ram_we_o || ee_we_o));
endmodule

bind smbd_cmd_dispatch smbd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .rd_req_i   (rd_req_i),
    .nv_wen_i   (nv_wen_i),
    .ack_vld_o  (ack_vld_o),
    .ack_o      (ack_o),
    .rd_vld_o   (rd_vld_o),
    .ram_we_o   (ram_we_o),
    .ee_we_o    (ee_we_o),
    .busy_o     (busy_o)
);

// File: tb/smbd_cmd_dispatch_tb.sv
module smbd_cmd_dispatch_tb;
    localparam int PROG = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 0, rw_i = 0, stop_i = 0, byte_vld_i = 0, rd_req_i = 0, nv_wen_i = 0;
    logic [7:0] byte_i = 0;
    logic [7:0] ram_rdata, ee_rdata, rd_data_o, ram_wdata_o, ee_wdata_o;
    logic ack_vld_o, ack_o, rd_vld_o, ram_we_o, ee_we_o, busy_o;
    logic [6:0] ram_addr_o;
    logic [8:0] ee_addr_o;

    logic [7:0] ram_mem [128];
    logic [7:0] ee_mem  [512];
    int ee_strobes = 0;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smbd_cmd_dispatch #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .rw_i(rw_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i),
        .nv_wen_i(nv_wen_i), .ram_rdata_i(ram_rdata), .ee_rdata_i(ee_rdata),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_vld_o(rd_vld_o),
        .rd_data_o(rd_data_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .ee_we_o(ee_we_o), .ee_addr_o(ee_addr_o),
        .ee_wdata_o(ee_wdata_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] ee_init(input int i);
        return 8'((i * 5 + 1) ^ (i >> 8));
    endfunction
    function automatic logic [7:0] ram_pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // storage models outside the block
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) ram_mem[i] <= 8'h00;
            for (int i = 0; i < 512; i++) ee_mem[i] <= ee_init(i);
        end else begin
            if (ram_we_o) ram_mem[ram_addr_o] <= ram_wdata_o;
            if (ee_we_o) begin
                ee_mem[ee_addr_o] <= ee_wdata_o;
                ee_strobes <= ee_strobes + 1;
            end
        end
    end
    assign ram_rdata = ram_mem[ram_addr_o];
    assign ee_rdata  = ee_mem[ee_addr_o];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev_start(input bit rw, output bit ack);
        @(negedge clk); start_i = 1; rw_i = rw;
        @(negedge clk); start_i = 0;
        check(ack_vld_o === 1'b1, "R10 start ack timing", ack_vld_o, 1);
        ack = ack_o;
    endtask

    task automatic ev_byte(input logic [7:0] b, output bit ack);
        @(negedge clk); byte_vld_i = 1; byte_i = b;
        @(negedge clk); byte_vld_i = 0;
        check(ack_vld_o === 1'b1, "R10 byte ack timing", ack_vld_o, 1);
        ack = ack_o;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop_i = 1;
        @(negedge clk); stop_i = 0;
    endtask

    task automatic ev_read(output logic [7:0] d);
        @(negedge clk); rd_req_i = 1;
        @(negedge clk); rd_req_i = 0;
        check(rd_vld_o === 1'b1, "R10 read timing", rd_vld_o, 1);
        d = rd_data_o;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit a1, a2, a3;
        logic [7:0] d;
        int n, bad;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check(!busy_o && !ack_vld_o && !rd_vld_o && !ram_we_o && !ee_we_o,
              "R11 outputs idle", {busy_o, ack_vld_o, rd_vld_o, ram_we_o, ee_we_o}, 0);
        check(ram_addr_o == 0 && ee_addr_o == 0, "R11 pointers zero",
              {ee_addr_o, ram_addr_o}, 0);
        ev_start(1, a1); ev_read(d);
        check(d == 8'h00, "R11 register file selected", d, 0);
        ev_stop();

        // R2 sweep: single-byte write at every register-file address
        for (int a = 0; a < 128; a++) begin
            ev_start(0, a1); ev_byte(8'(a), a2); ev_byte(ram_pat(a), a3);
            check(a1 && a2 && a3, "R2 write byte acks", {a1, a2, a3}, 3'b111);
            ev_stop();
        end
        bad = 0;
        for (int a = 0; a < 128; a++) if (ram_mem[a] != ram_pat(a)) bad++;
        check(bad == 0, "R2 register file contents", bad, 0);
        // R2 second data byte refused
        ev_start(0, a1); ev_byte(8'h10, a2); ev_byte(8'hEE, a2); ev_byte(8'h99, a3);
        check(!a3, "R2 extra byte NACK", a3, 0);
        ev_stop();
        check(ram_mem[16] == 8'hEE && ram_mem[17] == ram_pat(17),
              "R2 extra byte no write", ram_mem[17], ram_pat(17));

        // R1/R7 send byte then read, across stop and repeated start
        for (int a = 0; a < 128; a += 3) begin
            ev_start(0, a1); ev_byte(8'(a), a2);
            if (a % 2 == 1) ev_stop();
            ev_start(1, a3); ev_read(d);
            check(d == (a == 16 ? 8'hEE : ram_pat(a)), "R1 R7 pointer read", d,
                  a == 16 ? 8'hEE : ram_pat(a));
            ev_stop();
        end

        // R6 register-file wrap during a block read
        ev_start(0, a1); ev_byte(8'h7E, a2); ev_start(1, a3);
        for (int k = 0; k < 4; k++) begin
            ev_read(d);
            check(d == ram_pat((126 + k) % 128), "R6 ram wrap read", d, ram_pat((126 + k) % 128));
        end
        ev_stop();
        // R6 read outside a read transaction
        ev_start(0, a1); ev_byte(8'h05, a2); ev_read(d);
        check(d == 8'hFF, "R6 read fill", d, 8'hFF);
        ev_stop();

        // R9 every undefined command
        n = ee_strobes;
        for (int c = 128; c < 256; c++) begin
            if (c == 8'h80 || c == 8'h81 || c == 8'hA0) continue;
            ev_start(0, a1); ev_byte(8'(c), a2); ev_byte(8'h55, a3);
            check(a1 && !a2 && !a3, "R9 undefined command NACK", {a1, a2, a3}, 3'b100);
            ev_stop();
        end
        bad = 0;
        for (int a = 0; a < 128; a++)
            if (ram_mem[a] != (a == 16 ? 8'hEE : ram_pat(a))) bad++;
        check(bad == 0 && ee_strobes == n, "R9 no memory change", bad, 0);
        ev_start(1, a1); ev_read(d);
        check(d == ram_pat(5), "R9 pointer kept", d, ram_pat(5));
        ev_stop();

        // R3 nonvolatile pointer load, then wrap read (R6)
        ev_start(0, a1); ev_byte(8'h81, a2); ev_byte(8'hFE, a3);
        check(a1 && a2 && a3 && !busy_o, "R3 pointer load acks", {a1, a2, a3}, 3'b111);
        ev_start(1, a1);
        for (int k = 0; k < 3; k++) begin
            ev_read(d);
            check(d == ee_init((510 + k) % 512), "R3 R6 ee wrap read", d, ee_init((510 + k) % 512));
        end
        ev_stop();
        check(ee_strobes == n, "R3 no strobe", ee_strobes, n);

        // R4 locked write
        nv_wen_i = 0;
        ev_start(0, a1); ev_byte(8'h80, a2); ev_byte(8'h10, a2); ev_byte(8'hC3, a3);
        check(!a3 && !busy_o && ee_strobes == n, "R4 locked write refused", a3, 0);
        ev_stop();
        check(ee_mem[16] == ee_init(16), "R4 locked cell", ee_mem[16], ee_init(16));

        // R4/R8 enabled write and busy length
        nv_wen_i = 1;
        ev_start(0, a1); ev_byte(8'h81, a2); ev_byte(8'h20, a2); ev_byte(8'hC3, a3);
        check(a3, "R4 enabled write ack", a3, 1);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        check(n == PROG, "R8 busy length", n, PROG);
        ev_stop();
        check(ee_mem[288] == 8'hC3, "R4 ee cell written", ee_mem[288], 8'hC3);
        ev_start(0, a1); ev_byte(8'h81, a2); ev_byte(8'h20, a2); ev_start(1, a3);
        ev_read(d);
        check(d == 8'hC3, "R4 R7 ee read back", d, 8'hC3);
        ev_stop();
        // R8 access refused while busy
        ev_start(0, a1); ev_byte(8'h80, a2); ev_byte(8'h00, a2); ev_byte(8'h77, a3);
        ev_stop();
        ev_start(1, a1);
        check(!a1, "R8 start NACK while busy", a1, 0);
        ev_read(d);
        check(d == 8'hFF, "R8 refused read", d, 8'hFF);
        ev_stop();
        wait_idle();

        // R5 block write into the register file with wrap
        ev_start(0, a1); ev_byte(8'h7E, a2); ev_stop();
        ev_start(0, a1); ev_byte(8'hA0, a2); ev_byte(8'h03, a3);
        check(a1 && a2 && a3, "R5 block header acks", {a1, a2, a3}, 3'b111);
        for (int k = 0; k < 3; k++) begin
            ev_byte(8'hB0 + 8'(k), a1);
            check(a1, "R5 block data ack", a1, 1);
        end
        ev_byte(8'hBF, a1);
        check(!a1, "R5 beyond count NACK", a1, 0);
        ev_stop();
        check(ram_mem[126] == 8'hB0 && ram_mem[127] == 8'hB1 && ram_mem[0] == 8'hB2 &&
              ram_mem[1] == ram_pat(1), "R5 ram block contents", ram_mem[1], ram_pat(1));

        // R5/R8 block write into the nonvolatile array
        ev_start(0, a1); ev_byte(8'h81, a2); ev_byte(8'hFF, a3); ev_stop();
        n = ee_strobes;
        ev_start(0, a1); ev_byte(8'hA0, a2); ev_byte(8'h02, a3);
        ev_byte(8'h11, a1);
        ev_byte(8'h22, a2);
        check(a1 && !a2, "R8 block byte NACK while busy", {a1, a2}, 2'b10);
        ev_stop();
        wait_idle();
        ev_start(0, a1); ev_byte(8'hA0, a2); ev_byte(8'h01, a3); ev_byte(8'h33, a1);
        check(a1, "R5 ee block data ack", a1, 1);
        wait_idle();
        ev_byte(8'h44, a2);
        check(!a2, "R5 ee beyond count NACK", a2, 0);
        ev_stop();
        check(ee_mem[511] == 8'h11 && ee_mem[0] == 8'h33 && ee_mem[1] == ee_init(1) &&
              ee_strobes == n + 2, "R5 R6 ee block contents", ee_strobes, n + 2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule